// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block is a 64-bit adder/subtractor whose carry chain can be cut at byte, halfword or word boundaries. One wide adder then does one full-width add, two 32-bit adds, four 16-bit adds or eight 8-bit adds at once. Each packed sub-word is handled on its own, and no carry ever passes from one packed lane into the next. A datapath needs no separate narrow adders to run the same operation across many small integers.

A two-bit size select picks the lane width and a single control bit picks add or subtract. Subtraction inverts the second operand and injects a carry of one at the bottom of every lane. Each lane wraps around modulo its own width and never saturates. Every lane reports its carry-out in a vector indexed by lane number. The sum and the carry vector are registered once, so they follow the inputs by one clock.

Top module: `simd_part_adder`

## Requirements
- R1: With laneMode = 2'b00, sumOut[8k+7:8k] equals (opA[8k+7:8k] op opB[8k+7:8k]) mod 256 for each k in 0..7.
- R2: With laneMode = 2'b01, each of the four 16-bit fields sumOut[16k+15:16k] holds the result for that field alone, mod 2^16.
- R3: With laneMode = 2'b10, the two 32-bit halves are computed on their own, each mod 2^32.
- R4: With laneMode = 2'b11, sumOut is the full 64-bit result mod 2^64.
- R5: No carry crosses a lane boundary. When every lane holds all ones and 1 is added to each lane, every lane of the sum is zero.
- R6: With doSub = 1, each lane computes A + ~B + 1 within the lane, which is A minus B with wraparound. With doSub = 0 it computes A + B.
- R7: carryOut[k] is the carry out of the top bit of lane k. For an add it is 1 on unsigned overflow. For a subtract it is 1 when A >= B (unsigned), meaning no borrow.
- R8: carryOut[k] is 0 for every k at or above the lane count: 8, 4, 2 or 1 lanes for modes 00, 01, 10 and 11.
- R9: Outputs show the inputs sampled at the previous rising clk edge and do not change between edges. While rstN is low, sumOut and carryOut are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| laneMode | input | 2 | Lane size: 00=8, 01=16, 10=32, 11=64 bits |
| doSub | input | 1 | 1 = subtract opB from opA, 0 = add |
| sumOut | output | 64 | Registered packed result |
| carryOut | output | 8 | Registered carry-out per lane, indexed by lane |

## Verification
The hardest case to bring about from the ports is a carry that would cross into the next lane. It only shows when a lane is all ones and the added value pushes past the top of that lane. The sweep therefore gives every lane the same boundary-heavy value (all ones, top-bit-only, zero, one) against a value of one in the low bit of each lane, in every mode and for both operations. A full 64-bit reference sum is compared per lane, so any carry that leaks into a neighbour shows up in the next lane's field.

// File: rtl/simd_adder_pkg.sv
package simd_adder_pkg;
  localparam int DATA_W    = 64;
  localparam int UNIT_W    = 8;
  localparam int NUM_UNITS = DATA_W / UNIT_W;
  localparam int MODE_W    = 2;
  localparam int NUM_SIZES = $clog2(NUM_UNITS) + 1;

  typedef struct packed {
    logic [NUM_UNITS-1:0] cutBefore;  // unit starts a new lane
    logic                 invertB;    // subtract: invert B, carry-in of one
    logic [MODE_W-1:0]    sizeSel;    // log2 of units per lane
  } ctrlStrobes_t;
endpackage

// File: rtl/simd_adder_ctrl.sv
module simd_adder_ctrl
  import simd_adder_pkg::*;
(
  input  logic [MODE_W-1:0] laneMode,
  input  logic              doSub,
  output ctrlStrobes_t      strobes
);
  logic [NUM_UNITS-1:0] cutMask;

  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      cutMask[i] = ((i & ((1 << laneMode) - 1)) == 0);
    end
  end

  assign strobes.cutBefore = cutMask;
  assign strobes.invertB   = doSub;
  assign strobes.sizeSel   = laneMode;
endmodule

// File: rtl/simd_adder_datapath.sv
module simd_adder_datapath
  import simd_adder_pkg::*;
(
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  input  ctrlStrobes_t         strobes,
  output logic [DATA_W-1:0]    sumNext,
  output logic [NUM_UNITS-1:0] carryNext
);
  logic [NUM_UNITS-1:0] unitCarry;
  logic [NUM_UNITS-1:0] unitCin;
  logic [NUM_UNITS-1:0] carryBySize [NUM_SIZES];

  genvar u;
  generate
    for (u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic [UNIT_W-1:0] bEff;
      assign bEff = opB[u*UNIT_W +: UNIT_W] ^ {UNIT_W{strobes.invertB}};
      if (u == 0) begin : g_first
        assign unitCin[u] = strobes.invertB;
      end else begin : g_rest
        assign unitCin[u] = strobes.cutBefore[u] ? strobes.invertB : unitCarry[u-1];
      end
      assign {unitCarry[u], sumNext[u*UNIT_W +: UNIT_W]} =
        {1'b0, opA[u*UNIT_W +: UNIT_W]} + {1'b0, bEff} + {{UNIT_W{1'b0}}, unitCin[u]};
    end
  endgenerate

  genvar s, k;
  generate
    for (s = 0; s < NUM_SIZES; s++) begin : g_size
      for (k = 0; k < NUM_UNITS; k++) begin : g_lane
        if (((k + 1) << s) <= NUM_UNITS) begin : g_live
          assign carryBySize[s][k] = unitCarry[((k + 1) << s) - 1];
        end else begin : g_dead
          assign carryBySize[s][k] = 1'b0;
        end
      end
    end
  endgenerate

  assign carryNext = carryBySize[strobes.sizeSel];
endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder
  import simd_adder_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       opA,
  input  logic [63:0]       opB,
  input  logic [1:0]        laneMode,
  input  logic              doSub,
  output logic [63:0]       sumOut,
  output logic [7:0]        carryOut
);
  ctrlStrobes_t         strobes;
  logic [DATA_W-1:0]    sumNext;
  logic [NUM_UNITS-1:0] carryNext;

  simd_adder_ctrl u_ctrl (
    .laneMode (laneMode),
    .doSub    (doSub),
    .strobes  (strobes)
  );

  simd_adder_datapath u_dp (
    .opA       (opA),
    .opB       (opB),
    .strobes   (strobes),
    .sumNext   (sumNext),
    .carryNext (carryNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumOut   <= '0;
      carryOut <= '0;
    end else begin
      sumOut   <= sumNext;
      carryOut <= carryNext;
    end
  end

  p_full_width_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (laneMode == 2'b11) |=> (carryOut[7:1] == 7'b0));
  p_word_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (laneMode == 2'b10) |=> (carryOut[7:2] == 6'b0));
  p_half_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (laneMode == 2'b01) |=> (carryOut[7:4] == 4'b0));
  p_byte0_add_r1: assert property (@(posedge clk) disable iff (!rstN)
    (laneMode == 2'b00 && !doSub) |=>
      (sumOut[7:0] == 8'($past(opA[7:0]) + $past(opB[7:0]))));
  p_self_sub_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doSub && opA == opB) |=> (sumOut == 64'b0 && carryOut[0]));
  p_reset_clear_r9: assert property (@(posedge clk)
    !rstN |=> (sumOut == 64'b0 && carryOut == 8'b0));
endmodule

// File: tb/simd_part_adder_test.sv
module simd_part_adder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [1:0]  laneMode = '0;
  logic        doSub = 1'b0;
  logic [63:0] sumOut;
  logic [7:0]  carryOut;
  int checkCount = 0, failCount = 0;
  bit done = 0;
  logic [63:0] prevSum = '0;
  logic [7:0]  prevCarry = '0;

  always #10 clk = ~clk;

  simd_part_adder uut (.clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .laneMode(laneMode), .doSub(doSub), .sumOut(sumOut), .carryOut(carryOut));

  function automatic void refModel(input logic [63:0] a, input logic [63:0] b,
      input logic [1:0] m, input logic s, output logic [63:0] r, output logic [7:0] c);
    int w = 8 << m;
    int n = 64 / w;
    r = '0; c = '0;
    for (int k = 0; k < n; k++) begin
      logic [64:0] la, lb, t;
      la = '0; lb = '0;
      for (int j = 0; j < w; j++) begin
        la[j] = a[k*w+j];
        lb[j] = s ? ~b[k*w+j] : b[k*w+j];
      end
      t = la + lb + {64'b0, s};
      for (int j = 0; j < w; j++) r[k*w+j] = t[j];
      c[k] = t[w];
    end
  endfunction

  function automatic logic [63:0] spread(input logic [63:0] v, input logic [1:0] m);
    int w = 8 << m;
    logic [63:0] r = '0;
    for (int k = 0; k < 64 / w; k++)
      for (int j = 0; j < w; j++) r[k*w+j] = v[j];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runVec(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
      input logic s, input string tag);
    logic [63:0] er; logic [7:0] ec;
    string sumTag;
    refModel(a, b, m, s, er, ec);
    opA = a; opB = b; laneMode = m; doSub = s;
    #1;
    check(sumOut == prevSum && carryOut == prevCarry, "R9 hold", sumOut, prevSum);
    @(negedge clk);
    if (tag != "") sumTag = tag;
    else if (s) sumTag = "R6";
    else sumTag = (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
    check(sumOut == er, sumTag, sumOut, er);
    check(carryOut == ec, "R7 R8 carry", {56'b0, carryOut}, {56'b0, ec});
    prevSum = er; prevCarry = ec;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [63:0] lfsrA, lfsrB;
    opA = 64'hFFFF_FFFF_FFFF_FFFF; opB = 64'h1; doSub = 1'b0;
    repeat (3) @(negedge clk);
    check(sumOut == 64'b0 && carryOut == 8'b0, "R9 reset", sumOut, 64'b0);
    rstN = 1'b1;
    for (int mi = 0; mi < 4; mi++) begin
      logic [1:0] m = 2'(mi);
      // R5: all-ones lanes plus one per lane must give zero everywhere
      runVec(64'hFFFF_FFFF_FFFF_FFFF, spread(64'h1, m), m, 1'b0, "R5");
      runVec(spread(64'h0, m), spread(64'h1, m), m, 1'b1, "R5 R6 borrow");
      for (int si = 0; si < 2; si++) begin
        logic [63:0] corners [6];
        corners[0] = 64'h0; corners[1] = 64'h1;
        corners[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        corners[3] = 64'h8000_0000_0000_0000 >> (56 - (8 << m) + 8);
        corners[4] = ~corners[3] & ((64'h1 << (8 << m)) - 1);
        corners[5] = 64'h5A5A_5A5A_5A5A_5A5A;
        if (m == 2'b11) corners[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            runVec(spread(corners[i], m), spread(corners[j], m), m, 1'(si), "");
        for (int i = 0; i < 256; i += 17)
          for (int j = 0; j < 256; j += 17) begin
            logic [63:0] a = '0, b = '0;
            for (int k = 0; k < 8; k++) begin
              a[k*8 +: 8] = 8'(i + k * 37);
              b[k*8 +: 8] = 8'(j + k * 91);
            end
            runVec(a, b, m, 1'(si), "");
          end
      end
    end
    lfsrA = 64'hACE1_2468_1357_9BDF; lfsrB = 64'h0F1E_2D3C_4B5A_6978;
    for (int n = 0; n < 400; n++) begin
      lfsrA = {lfsrA[62:0], lfsrA[63] ^ lfsrA[62] ^ lfsrA[60] ^ lfsrA[59]};
      lfsrB = {lfsrB[62:0], lfsrB[63] ^ lfsrB[62] ^ lfsrB[60] ^ lfsrB[59]};
      runVec(lfsrA, lfsrB ^ {lfsrA[31:0], lfsrA[63:32]}, 2'(n % 4), 1'((n / 4) % 2), "");
    end
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(sumOut == 64'b0 && carryOut == 8'b0, "R9 reset after run", sumOut, 64'b0);
    done = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule